// File: doc/BRIEF.md
# Multicycle Accumulator Machine Sequencer

This block is the control core of a small accumulator computer. It keeps the program counter, the instruction register, the accumulator, the data register and the carry flag. It runs every instruction as a series of phases: fetch, decode, an optional operand read, then execute. A program memory, a data memory and an arithmetic unit sit outside the block, and each one is reached through its own request/done channel.

A request works like a valid signal and its done works like a ready signal, so each subordinate unit can stall the sequencer for as long as it needs. Once the sequencer raises a request, it keeps the request and the request's address and operand fields steady until the matching done is sampled. The request falls on the next clock edge. A done that arrives while no request is pending has no effect.

After reset the sequencer sits idle until a start pulse arrives. A halt instruction stops it and raises `finished`. The next start resumes execution at the word that follows the halt.

Top module: `acc_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in the idle fetch phase. It clears the program counter, instruction register, accumulator, data register and carry flag, and it drives `pm_req`, `dm_req`, `alu_req` and `finished` low.
- R2: While the sequencer is idle, no request is raised. A start pulse seen while idle begins fetching at the current program counter. A start pulse seen while a program is running has no effect.
- R3: Instructions run one at a time in the order fetch, decode, operand read (when needed), execute, and then back to fetch. At most one request is high in any cycle.
- R4: A fetch raises `pm_req` with `pm_addr` equal to the program counter. When the fetch completes, the instruction register takes `pm_data` and the program counter increments by one, wrapping at its width.
- R5: An instruction word holds the opcode in bits [15:10] and the operand address in bits [9:0]. `dm_addr` carries the address field and `alu_op` carries the opcode.
- R6: The operand read takes place only when opcode bit 5 is 0. It loads `dm_rdata` into the data register. When opcode bit 5 is 1, the read is skipped and the data register keeps its value.
- R7: During execute, `alu_acc`, `alu_dr`, `alu_cin` and `alu_op` present the accumulator, the data register, the carry flag and the opcode. On done, the accumulator takes `alu_result` and the carry flag takes `alu_carry`.
- R8: Every request stays high, with its address and operand fields stable, until its done is sampled. The request is low in the cycle that follows, and a done with no pending request is ignored.
- R9: Opcode 6'h3F is a halt. It performs no operand read and no execute, it raises `finished`, and it stops sequencing. The next start resumes at the address after the halt.
- R10: `finished` falls in the cycle after a start pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin or resume running when idle |
| finished | output | 1 | High after a halt, until the next start |
| pm_req | output | 1 | Program memory read request |
| pm_addr | output | 10 | Program counter, used as the fetch address |
| pm_done | input | 1 | Program memory read complete |
| pm_data | input | 16 | Instruction word |
| dm_req | output | 1 | Data memory read request |
| dm_addr | output | 10 | Operand address |
| dm_done | input | 1 | Data memory read complete |
| dm_rdata | input | 16 | Operand word |
| alu_req | output | 1 | Arithmetic operation request |
| alu_op | output | 6 | Opcode presented to the arithmetic unit |
| alu_acc | output | 16 | Accumulator operand |
| alu_dr | output | 16 | Data register operand |
| alu_cin | output | 1 | Carry flag operand |
| alu_done | input | 1 | Arithmetic operation complete |
| alu_result | input | 16 | New accumulator value |
| alu_carry | input | 1 | New carry flag |

## Verification
The assertions check the channel discipline on every cycle. They check that a request holds until its done and then falls, that at most one request is high, and that addresses stay steady while a read is pending. They also check that the program counter steps by one after each fetch, that no operand read is raised for an opcode with bit 5 set, that a halt opcode never reaches the arithmetic unit, and that all outputs are quiet after reset. Only the bench scenarios can show that the accumulator, data register and carry flag carry the correct values from one instruction to the next. The same holds for three other behaviours: that a start pulse is ignored while running, that a halt resumes at the following address, and that a mid-program reset clears the state that later instructions read.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_READ   = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  localparam int CH_PROG = 0;
  localparam int CH_DATA = 1;
  localparam int CH_ALU  = 2;
  localparam int NUM_CH  = 3;

  // Phase in which a given channel is allowed to issue its request.
  function automatic phase_e ch_phase(input int ch);
    case (ch)
      CH_PROG: return PH_FETCH;
      CH_DATA: return PH_READ;
      default: return PH_EXEC;
    endcase
  endfunction

endpackage

// File: rtl/acc_seq_chan.sv
// One request/done channel: raises req when go is seen, holds it until done,
// then drops it; fire marks the completing cycle.
module acc_seq_chan (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic done,
  output logic req,
  output logic fire
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (req_q && done) begin
      req_q <= 1'b0;
    end else if (go && !req_q) begin
      req_q <= 1'b1;
    end
  end

  assign req  = req_q;
  assign fire = req_q && done;

endmodule

// File: rtl/acc_seq_decode.sv
// Splits an instruction word and classifies its opcode.
module acc_seq_decode #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 10
) (
  input  logic [OP_W+ADDR_W-1:0] instr,
  output logic [OP_W-1:0]        opcode,
  output logic [ADDR_W-1:0]      addr,
  output logic                   is_halt,
  output logic                   needs_operand
);

  localparam int              INSTR_W = OP_W + ADDR_W;
  localparam int              MEM_BIT = OP_W - 1;
  localparam logic [OP_W-1:0] HALT_OP = '1;

  assign opcode        = instr[INSTR_W-1:ADDR_W];
  assign addr          = instr[ADDR_W-1:0];
  assign is_halt       = (opcode == HALT_OP);
  assign needs_operand = !opcode[MEM_BIT];

endmodule

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     finished,
  output logic                     pm_req,
  output logic [ADDR_W-1:0]        pm_addr,
  input  logic                     pm_done,
  input  logic [OP_W+ADDR_W-1:0]   pm_data,
  output logic                     dm_req,
  output logic [ADDR_W-1:0]        dm_addr,
  input  logic                     dm_done,
  input  logic [DATA_W-1:0]        dm_rdata,
  output logic                     alu_req,
  output logic [OP_W-1:0]          alu_op,
  output logic [DATA_W-1:0]        alu_acc,
  output logic [DATA_W-1:0]        alu_dr,
  output logic                     alu_cin,
  input  logic                     alu_done,
  input  logic [DATA_W-1:0]        alu_result,
  input  logic                     alu_carry
);
  import acc_seq_pkg::*;

  localparam int INSTR_W = OP_W + ADDR_W;

  phase_e              phase_q;
  logic                running_q;
  logic                finished_q;
  logic [ADDR_W-1:0]   pc_q;
  logic [INSTR_W-1:0]  ir_q;
  logic [OP_W-1:0]     op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   ac_q;
  logic [DATA_W-1:0]   dr_q;
  logic                e_q;

  logic [NUM_CH-1:0]   ch_go;
  logic [NUM_CH-1:0]   ch_done;
  logic [NUM_CH-1:0]   ch_req;
  logic [NUM_CH-1:0]   ch_fire;

  logic [OP_W-1:0]     dec_op;
  logic [ADDR_W-1:0]   dec_addr;
  logic                dec_halt;
  logic                dec_mem;

  assign ch_done[CH_PROG] = pm_done;
  assign ch_done[CH_DATA] = dm_done;
  assign ch_done[CH_ALU]  = alu_done;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_go[c] = running_q && (phase_q == ch_phase(c));
    acc_seq_chan u_chan (
      .clk  (clk),
      .rst  (rst),
      .go   (ch_go[c]),
      .done (ch_done[c]),
      .req  (ch_req[c]),
      .fire (ch_fire[c])
    );
  end

  acc_seq_decode #(
    .OP_W   (OP_W),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .instr         (ir_q),
    .opcode        (dec_op),
    .addr          (dec_addr),
    .is_halt       (dec_halt),
    .needs_operand (dec_mem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_FETCH;
      running_q  <= 1'b0;
      finished_q <= 1'b0;
      pc_q       <= '0;
      ir_q       <= '0;
      op_q       <= '0;
      addr_q     <= '0;
      ac_q       <= '0;
      dr_q       <= '0;
      e_q        <= 1'b0;
    end else begin
      case (phase_q)
        PH_FETCH: begin
          if (!running_q) begin
            if (start) begin
              running_q  <= 1'b1;
              finished_q <= 1'b0;
            end
          end else if (ch_fire[CH_PROG]) begin
            ir_q    <= pm_data;
            pc_q    <= pc_q + 1'b1;
            phase_q <= PH_DECODE;
          end
        end
        PH_DECODE: begin
          op_q   <= dec_op;
          addr_q <= dec_addr;
          if (dec_halt) begin
            running_q  <= 1'b0;
            finished_q <= 1'b1;
            phase_q    <= PH_FETCH;
          end else if (dec_mem) begin
            phase_q <= PH_READ;
          end else begin
            phase_q <= PH_EXEC;
          end
        end
        PH_READ: begin
          if (ch_fire[CH_DATA]) begin
            dr_q    <= dm_rdata;
            phase_q <= PH_EXEC;
          end
        end
        PH_EXEC: begin
          if (ch_fire[CH_ALU]) begin
            ac_q    <= alu_result;
            e_q     <= alu_carry;
            phase_q <= PH_FETCH;
          end
        end
        default: phase_q <= PH_FETCH;
      endcase
    end
  end

  assign finished = finished_q;
  assign pm_req   = ch_req[CH_PROG];
  assign pm_addr  = pc_q;
  assign dm_req   = ch_req[CH_DATA];
  assign dm_addr  = addr_q;
  assign alu_req  = ch_req[CH_ALU];
  assign alu_op   = op_q;
  assign alu_acc  = ac_q;
  assign alu_dr   = dr_q;
  assign alu_cin  = e_q;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int OP_W   = 6,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              finished,
  input logic              pm_req,
  input logic [ADDR_W-1:0] pm_addr,
  input logic              pm_done,
  input logic              dm_req,
  input logic [ADDR_W-1:0] dm_addr,
  input logic              dm_done,
  input logic              alu_req,
  input logic [OP_W-1:0]   alu_op,
  input logic              alu_done
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !pm_req && !dm_req && !alu_req && !finished);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    finished |-> !pm_req && !dm_req && !alu_req);

  p_one_req_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pm_req, dm_req, alu_req}));

  p_pc_step_r4: assert property (@(posedge clk) disable iff (rst)
    pm_req && pm_done |=> pm_addr == $past(pm_addr) + 1'b1);

  p_dm_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    dm_req && !dm_done |=> $stable(dm_addr));

  p_read_gate_r6: assert property (@(posedge clk) disable iff (rst)
    dm_req |-> !alu_op[OP_W-1]);

  p_op_hold_r7: assert property (@(posedge clk) disable iff (rst)
    alu_req && !alu_done |=> $stable(alu_op));

  p_pm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    pm_req && !pm_done |=> pm_req && $stable(pm_addr));

  p_dm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    dm_req && !dm_done |=> dm_req);

  p_alu_hold_r8: assert property (@(posedge clk) disable iff (rst)
    alu_req && !alu_done |=> alu_req);

  p_pm_drop_r8: assert property (@(posedge clk) disable iff (rst)
    pm_req && pm_done |=> !pm_req);

  p_dm_drop_r8: assert property (@(posedge clk) disable iff (rst)
    dm_req && dm_done |=> !dm_req);

  p_alu_drop_r8: assert property (@(posedge clk) disable iff (rst)
    alu_req && alu_done |=> !alu_req);

  p_no_halt_exec_r9: assert property (@(posedge clk) disable iff (rst)
    alu_req |-> alu_op != '1);

endmodule

bind acc_seq acc_seq_chk #(
  .OP_W   (OP_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .finished (finished),
  .pm_req   (pm_req),
  .pm_addr  (pm_addr),
  .pm_done  (pm_done),
  .dm_req   (dm_req),
  .dm_addr  (dm_addr),
  .dm_done  (dm_done),
  .alu_req  (alu_req),
  .alu_op   (alu_op),
  .alu_done (alu_done)
);

// File: tb/acc_seq_tb_top.sv
module acc_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 10;
  localparam int LOGN       = 64;

  // Vector: {expect operand read, instruction word}. Opcode [15:10], address [9:0].
  localparam logic [16:0] VEC [NPROG] = '{
    {1'b1, 16'h0802},  // load  mem[2]
    {1'b1, 16'h0401},  // add   mem[1] (carries out)
    {1'b1, 16'h0C03},  // add with carry mem[3]
    {1'b0, 16'h8400},  // increment
    {1'b0, 16'h8800},  // complement
    {1'b1, 16'h0405},  // add   mem[5]
    {1'b0, 16'h8000},  // no operation
    {1'b1, 16'h0801},  // load  mem[1]
    {1'b0, 16'h8400},  // increment
    {1'b0, 16'hFC00}   // halt
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic finished;
  logic pm_req, dm_req, alu_req;
  logic [9:0] pm_addr, dm_addr;
  logic pm_done, dm_done, alu_done;
  logic [15:0] pm_data, dm_rdata, alu_result;
  logic [5:0] alu_op;
  logic [15:0] alu_acc, alu_dr;
  logic alu_cin, alu_carry;

  logic pm_done_r = 1'b0, dm_done_r = 1'b0, alu_done_r = 1'b0;
  int   pm_cnt = 0, dm_cnt = 0, alu_cnt = 0;
  int   lat = 0;
  logic spur = 1'b0;

  logic [15:0] pmem [LOGN];
  logic [15:0] dmem [16];

  int errors = 0;
  int checks = 0;

  // Event logs
  int          fe_n = 0, ev_n = 0, dm_fires = 0;
  logic [9:0]  fe_addr [LOGN];
  logic [5:0]  ev_op   [LOGN];
  logic [15:0] ev_acc  [LOGN];
  logic [15:0] ev_dr   [LOGN];
  logic        ev_cin  [LOGN];
  int          ev_dmc  [LOGN];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .finished(finished),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_done(pm_done), .pm_data(pm_data),
    .dm_req(dm_req), .dm_addr(dm_addr), .dm_done(dm_done), .dm_rdata(dm_rdata),
    .alu_req(alu_req), .alu_op(alu_op), .alu_acc(alu_acc), .alu_dr(alu_dr),
    .alu_cin(alu_cin), .alu_done(alu_done), .alu_result(alu_result),
    .alu_carry(alu_carry)
  );

  function automatic logic [16:0] alu_f(input logic [5:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic c);
    case (op)
      6'h01:   return {1'b0, a} + {1'b0, b};
      6'h02:   return {1'b0, b};
      6'h03:   return {1'b0, a} + {1'b0, b} + {16'd0, c};
      6'h21:   return {1'b0, a} + 17'd1;
      6'h22:   return {1'b0, ~a};
      default: return {1'b0, a};
    endcase
  endfunction

  assign pm_done  = pm_done_r | spur;
  assign dm_done  = dm_done_r | spur;
  assign alu_done = alu_done_r | spur;
  assign pm_data  = pmem[pm_addr[5:0]];
  assign dm_rdata = dmem[dm_addr[3:0]];
  assign {alu_carry, alu_result} = alu_f(alu_op, alu_acc, alu_dr, alu_cin);

  // Subordinate responders with programmable latency
  always @(posedge clk) begin
    if (!pm_req) pm_cnt <= 0; else if (!pm_done_r) pm_cnt <= pm_cnt + 1;
    pm_done_r <= pm_req && !pm_done_r && (pm_cnt >= lat);
    if (!dm_req) dm_cnt <= 0; else if (!dm_done_r) dm_cnt <= dm_cnt + 1;
    dm_done_r <= dm_req && !dm_done_r && (dm_cnt >= lat);
    if (!alu_req) alu_cnt <= 0; else if (!alu_done_r) alu_cnt <= alu_cnt + 1;
    alu_done_r <= alu_req && !alu_done_r && (alu_cnt >= lat);
  end

  // Monitor: log completed handshakes between edges
  always @(negedge clk) begin
    if (!rst && !spur) begin
      if (pm_req && pm_done && fe_n < LOGN) begin
        fe_addr[fe_n] = pm_addr;
        fe_n = fe_n + 1;
      end
      if (dm_req && dm_done) dm_fires = dm_fires + 1;
      if (alu_req && alu_done && ev_n < LOGN) begin
        ev_op[ev_n]  = alu_op;
        ev_acc[ev_n] = alu_acc;
        ev_dr[ev_n]  = alu_dr;
        ev_cin[ev_n] = alu_cin;
        ev_dmc[ev_n] = dm_fires;
        ev_n = ev_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    fe_n = 0; ev_n = 0; dm_fires = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_finished(input string rq);
    int n = 0;
    while (!finished && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(finished, rq, "finished after halt", {31'd0, finished}, 32'd1);
  endtask

  // Walk the vector table against the logged trace
  task automatic compare_trace(input string tag);
    logic [15:0] ac = '0, dr = '0;
    logic        e  = 1'b0;
    int          dmc = 0;
    logic [16:0] r;
    chk(fe_n == NPROG, "R3", {tag, " fetch count"}, fe_n, NPROG);
    chk(ev_n == NPROG - 1, "R9", {tag, " execute count (halt skips execute)"},
        ev_n, NPROG - 1);
    for (int i = 0; i < NPROG - 1; i++) begin
      logic [5:0] op = VEC[i][15:10];
      if (VEC[i][16]) begin
        dr = dmem[VEC[i][3:0]];
        dmc++;
      end
      chk(fe_addr[i] == 10'(i), "R4", {tag, " fetch address"}, fe_addr[i], i);
      chk(ev_op[i] == op, "R5", {tag, " opcode at execute"}, ev_op[i], op);
      chk(ev_dmc[i] == dmc, "R6", {tag, " operand reads so far"}, ev_dmc[i], dmc);
      chk(ev_dr[i] == dr, "R6", {tag, " data register at execute"}, ev_dr[i], dr);
      chk(ev_acc[i] == ac, "R7", {tag, " accumulator at execute"}, ev_acc[i], ac);
      chk(ev_cin[i] == e, "R7", {tag, " carry at execute"}, ev_cin[i], e);
      r  = alu_f(op, ac, dr, e);
      ac = r[15:0];
      e  = r[16];
    end
    chk(fe_addr[NPROG-1] == 10'(NPROG - 1), "R4", {tag, " halt fetch address"},
        fe_addr[NPROG-1], NPROG - 1);
    chk(pm_addr == 10'(NPROG), "R9", {tag, " PC past halt"}, pm_addr, NPROG);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < LOGN; i++)
      pmem[i] = (i < NPROG) ? VEC[i][15:0] : 16'hFC00;
    for (int i = 0; i < 16; i++)
      dmem[i] = 16'(i * 16'h0111 + 16'h0F00);
    dmem[1] = 16'hFFF0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state at ports
    chk(!pm_req && !dm_req && !alu_req, "R1", "strobes after reset",
        {pm_req, dm_req, alu_req}, 0);
    chk(!finished, "R1", "finished after reset", finished, 0);
    chk(pm_addr == 0 && alu_acc == 0 && alu_dr == 0 && !alu_cin, "R1",
        "registers after reset", {pm_addr, alu_cin}, 0);

    // R2: idle without start
    repeat (6) @(negedge clk);
    chk(fe_n == 0 && !pm_req, "R2", "no fetch before start", fe_n, 0);

    // Run 1: zero latency, extra start pulses while running are ignored (R2)
    lat = 0;
    clear_logs();
    pulse_start();
    repeat (8) @(negedge clk);
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    wait_finished("R9");
    compare_trace("run1");
    chk(!pm_req && !dm_req && !alu_req, "R9", "stopped after halt",
        {pm_req, dm_req, alu_req}, 0);

    // R8: done with no pending request is ignored
    @(negedge clk) spur = 1'b1;
    @(negedge clk) spur = 1'b0;
    repeat (3) @(negedge clk);
    chk(pm_addr == 10'(NPROG) && finished && !pm_req, "R8",
        "spurious done ignored", {pm_addr, finished}, {10'(NPROG), 1'b1});

    // Resume after halt, longer latency (R9, R10)
    lat = 2;
    clear_logs();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!finished, "R10", "finished falls after start", finished, 0);
    wait_finished("R9");
    chk(fe_n == 1 && fe_addr[0] == 10'(NPROG), "R9", "resume at address after halt",
        fe_addr[0], NPROG);
    chk(ev_n == 0, "R9", "halt word executes nothing", ev_n, 0);

    // Mid-program reset, then full rerun with latency 1 (R1)
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    lat = 1;
    clear_logs();
    pulse_start();
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!pm_req && !dm_req && !alu_req && !finished, "R1", "strobes after mid reset",
        {pm_req, dm_req, alu_req, finished}, 0);
    chk(pm_addr == 0 && alu_acc == 0 && alu_dr == 0 && !alu_cin, "R1",
        "registers after mid reset", {pm_addr, alu_cin}, 0);
    clear_logs();
    pulse_start();
    wait_finished("R9");
    compare_trace("run3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule